// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recent page translations so that a virtual address can be mapped to a physical address without going to the page table in memory. Pages are 4 KB, so the twelve low address bits pass through untouched and only the 20-bit virtual page number is compared. All sixteen slots are compared in parallel. The result of a lookup is registered and shows on the outputs in the cycle after the request. A miss is reported so that outside logic can fetch the entry, write it through the refill port, and retry the access.

Each slot holds a virtual page number, a physical page number, a valid bit, a used bit and a modified bit. A lookup that hits marks the slot used and, for a store, modified. The bits as they stood just before the access are returned with the result, which lets outside logic see when a page turns dirty for the first time. A refill lands in the slot that already holds the same page if there is one, otherwise in the lowest-numbered empty slot, otherwise in the least recently touched slot. Recency is tracked as a distinct age per slot. A flush empties the whole buffer in one cycle.

Top module: `vtc_top`

## Requirements
- R1: A lookup that hits gives, one cycle later, `lk_hit`=1 and `lk_paddr` = {stored physical page number, `lk_vaddr[11:0]`}.
- R2: A lookup with no valid matching slot gives `lk_miss`=1, `lk_hit`=0 and `lk_paddr`=0 one cycle later. A cycle without a lookup gives `lk_hit`=0 and `lk_miss`=0. The two are never both 1.
- R3: On a hit, `lk_prev_used` shows the slot's used bit before the access. Every hit sets that bit to 1.
- R4: On a hit, `lk_prev_dirty` shows the slot's modified bit before the access. A hit with `lk_write`=1 sets it. A read hit leaves it unchanged.
- R5: While any slot is empty, a refill of a new page evicts no valid translation.
- R6: When all slots are valid, a refill of a new page replaces the slot that has gone longest without a hit or a refill.
- R7: A refill of a page that is already held rewrites that slot's physical page and status bits and evicts nothing else.
- R8: After a cycle with `flush`=1, every lookup misses until a new refill. A refill issued in the same cycle as `flush` is discarded.
- R9: A lookup and a refill of the same page in one cycle hit, returning the refilled physical page and the refilled status bits as the prior bits.
- R10: After reset, all slots are empty and both result flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every slot |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_write | input | 1 | The lookup is a store |
| lk_vaddr | input | 32 | Virtual address to translate |
| fill_valid | input | 1 | Refill request this cycle |
| fill_vpn | input | 20 | Virtual page number being installed |
| fill_ppn | input | 20 | Physical page number being installed |
| fill_used | input | 1 | Initial used bit of the new entry |
| fill_dirty | input | 1 | Initial modified bit of the new entry |
| lk_hit | output | 1 | Registered: previous lookup hit |
| lk_miss | output | 1 | Registered: previous lookup missed |
| lk_paddr | output | 32 | Registered translated address (0 unless hit) |
| lk_prev_used | output | 1 | Used bit of the hit slot before the access |
| lk_prev_dirty | output | 1 | Modified bit of the hit slot before the access |

## Verification
Two pairs of functions can fall in the same cycle: a lookup with a refill, and a refill with a flush. Both pairs are provoked in directed steps, once where the lookup and the refill name the same page and once where they name different pages. The random phase drives all three inputs together from a small page pool, so collisions happen often. A behavioural model applies the refill before the lookup and the flush last. It compares the hit, miss, address and prior status outputs on every clock, so a wrong ordering shows up either at once or at the next lookup of the affected page.

// File: rtl/vtc_pkg.sv
package vtc_pkg;

    // Size of the untranslated page offset for 4 KB pages
    localparam int unsigned PAGE_OFF_W = 12;

    // Status kept with each translation
    typedef struct packed {
        logic used;
        logic dirty;
    } vtc_flags_t;

endpackage

// File: rtl/vtc_match.sv
// Parallel page comparator: one equality check per slot
module vtc_match #(
    parameter int unsigned N = 16,
    parameter int unsigned W = 20
) (
    input  logic [N-1:0]        valid,
    input  logic [N-1:0][W-1:0] tags,
    input  logic [W-1:0]        key,
    output logic [N-1:0]        hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = valid[g] && (tags[g] == key);
    end
endmodule

// File: rtl/vtc_victim.sv
// Slot choice for a refill: same page, else lowest empty, else oldest
module vtc_victim #(
    parameter int unsigned N  = 16,
    parameter int unsigned AW = 4
) (
    input  logic [N-1:0]         same_page,
    input  logic [N-1:0]         valid,
    input  logic [N-1:0][AW-1:0] age,
    output logic [AW-1:0]        slot
);
    logic found;

    always_comb begin
        slot  = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!found && same_page[i]) begin
                slot  = AW'(i);
                found = 1'b1;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (!found && !valid[i]) begin
                slot  = AW'(i);
                found = 1'b1;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (!found && age[i] == AW'(N - 1)) begin
                slot  = AW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vtc_top.sv
module vtc_top
    import vtc_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned VA_W    = 32,
    parameter int unsigned PA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              lk_valid,
    input  logic              lk_write,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              fill_valid,
    input  logic [VA_W-PAGE_OFF_W-1:0] fill_vpn,
    input  logic [PA_W-PAGE_OFF_W-1:0] fill_ppn,
    input  logic              fill_used,
    input  logic              fill_dirty,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [PA_W-1:0]   lk_paddr,
    output logic              lk_prev_used,
    output logic              lk_prev_dirty
);
    localparam int unsigned VPN_W = VA_W - PAGE_OFF_W;
    localparam int unsigned PPN_W = PA_W - PAGE_OFF_W;
    localparam int unsigned AW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef logic [ENTRIES-1:0][AW-1:0] age_arr_t;

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        vtc_flags_t [ENTRIES-1:0]       flags;
        logic [ENTRIES-1:0][VPN_W-1:0]  vpn;
        logic [ENTRIES-1:0][PPN_W-1:0]  ppn;
        age_arr_t                       age;
        logic                           hit;
        logic                           miss;
        logic [PA_W-1:0]                paddr;
        vtc_flags_t                     prev;
    } state_t;

    state_t s_d, s_q;

    // Move slot k to age 0; slots younger than k age by one
    function automatic age_arr_t touch(age_arr_t a, logic [AW-1:0] k);
        age_arr_t r;
        r = a;
        for (int i = 0; i < ENTRIES; i++) begin
            if (AW'(i) == k)
                r[i] = '0;
            else if (a[i] < a[k])
                r[i] = a[i] + AW'(1);
        end
        return r;
    endfunction

    logic [VPN_W-1:0]   lk_vpn;
    logic [ENTRIES-1:0] old_match, fill_match, hit_vec, age_max_vec;
    logic [AW-1:0]      victim, hit_idx;
    logic               fill_go;

    assign lk_vpn  = lk_vaddr[VA_W-1:PAGE_OFF_W];
    assign fill_go = fill_valid && !flush;

    vtc_match #(.N(ENTRIES), .W(VPN_W)) u_lk_match (
        .valid (s_q.valid),
        .tags  (s_q.vpn),
        .key   (lk_vpn),
        .hit   (old_match)
    );

    vtc_match #(.N(ENTRIES), .W(VPN_W)) u_fill_match (
        .valid (s_q.valid),
        .tags  (s_q.vpn),
        .key   (fill_vpn),
        .hit   (fill_match)
    );

    vtc_victim #(.N(ENTRIES), .AW(AW)) u_victim (
        .same_page (fill_match),
        .valid     (s_q.valid),
        .age       (s_q.age),
        .slot      (victim)
    );

    // Lookup sees the table as it stands after this cycle's refill
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (fill_go && victim == AW'(i))
                hit_vec[i] = (fill_vpn == lk_vpn);
            else
                hit_vec[i] = old_match[i];
            age_max_vec[i] = (s_q.age[i] == AW'(ENTRIES - 1));
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i])
                hit_idx = AW'(i);
        end
    end

    always_comb begin
        s_d       = s_q;
        s_d.hit   = 1'b0;
        s_d.miss  = 1'b0;
        s_d.paddr = '0;
        s_d.prev  = '0;

        if (fill_go) begin
            s_d.valid[victim]       = 1'b1;
            s_d.vpn[victim]         = fill_vpn;
            s_d.ppn[victim]         = fill_ppn;
            s_d.flags[victim].used  = fill_used;
            s_d.flags[victim].dirty = fill_dirty;
            s_d.age                 = touch(s_d.age, victim);
        end

        if (lk_valid) begin
            if (|hit_vec) begin
                s_d.hit   = 1'b1;
                s_d.paddr = {s_d.ppn[hit_idx], lk_vaddr[PAGE_OFF_W-1:0]};
                s_d.prev  = s_d.flags[hit_idx];
                s_d.flags[hit_idx].used = 1'b1;
                if (lk_write)
                    s_d.flags[hit_idx].dirty = 1'b1;
                s_d.age = touch(s_d.age, hit_idx);
            end else begin
                s_d.miss = 1'b1;
            end
        end

        if (flush)
            s_d.valid = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int i = 0; i < ENTRIES; i++)
                s_q.age[i] <= AW'(i);
        end else begin
            s_q <= s_d;
        end
    end

    assign lk_hit        = s_q.hit;
    assign lk_miss       = s_q.miss;
    assign lk_paddr      = s_q.paddr;
    assign lk_prev_used  = s_q.prev.used;
    assign lk_prev_dirty = s_q.prev.dirty;

    // R2: result flags are exclusive
    a_r2_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    // R2: a result only follows a request
    a_r2_result_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit || lk_miss) |-> $past(lk_valid));

    // R1: page offset passes through untranslated
    a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[PAGE_OFF_W-1:0] == $past(lk_vaddr[PAGE_OFF_W-1:0])));

    // R7: a page is never held in two slots
    a_r7_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(old_match));

    // R6: exactly one slot carries the oldest age
    a_r6_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(age_max_vec));

    // R8: a lookup right after a flush (without a refill) misses
    a_r8_flush_misses: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush) && lk_valid && !fill_valid) |=> lk_miss);

endmodule

// File: tb/vtc_top_tb_top.sv
module vtc_top_tb_top;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0;
    logic        lk_write = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic        fill_used = 1'b0;
    logic        fill_dirty = 1'b0;
    logic        lk_hit, lk_miss, lk_prev_used, lk_prev_dirty;
    logic [31:0] lk_paddr;

    always #4 clk = ~clk;

    vtc_top dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_vaddr(lk_vaddr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_used(fill_used), .fill_dirty(fill_dirty),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
        .lk_prev_used(lk_prev_used), .lk_prev_dirty(lk_prev_dirty)
    );

    // Behavioural reference
    bit          m_valid [N];
    bit [19:0]   m_vpn   [N];
    bit [19:0]   m_ppn   [N];
    bit          m_used  [N];
    bit          m_dirty [N];
    int          order[$];          // front = most recent
    bit          e_hit, e_miss, e_pu, e_pd;
    bit [31:0]   e_paddr;

    int    vectors = 0;
    int    fails   = 0;
    string cur_req = "R10";
    bit    done    = 1'b0;

    function automatic void m_touch(int s);
        foreach (order[k]) begin
            if (order[k] == s) begin
                order.delete(k);
                break;
            end
        end
        order.push_front(s);
    endfunction

    function automatic void m_reset();
        order = {};
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_used[i] = 0; m_dirty[i] = 0;
            m_vpn[i] = 0; m_ppn[i] = 0;
            order.push_back(i);
        end
        e_hit = 0; e_miss = 0; e_pu = 0; e_pd = 0; e_paddr = 0;
    endfunction

    function automatic void m_step();
        int v;
        int h;
        e_hit = 0; e_miss = 0; e_pu = 0; e_pd = 0; e_paddr = 0;
        if (fill_valid && !flush) begin
            v = -1;
            for (int i = 0; i < N; i++)
                if (v < 0 && m_valid[i] && m_vpn[i] == fill_vpn) v = i;
            for (int i = 0; i < N; i++)
                if (v < 0 && !m_valid[i]) v = i;
            if (v < 0) v = order[$];
            m_valid[v] = 1; m_vpn[v] = fill_vpn; m_ppn[v] = fill_ppn;
            m_used[v] = fill_used; m_dirty[v] = fill_dirty;
            m_touch(v);
        end
        if (lk_valid) begin
            h = -1;
            for (int i = 0; i < N; i++)
                if (m_valid[i] && m_vpn[i] == lk_vaddr[31:12]) h = i;
            if (h >= 0) begin
                e_hit = 1;
                e_paddr = {m_ppn[h], lk_vaddr[11:0]};
                e_pu = m_used[h]; e_pd = m_dirty[h];
                m_used[h] = 1;
                if (lk_write) m_dirty[h] = 1;
                m_touch(h);
            end else begin
                e_miss = 1;
            end
        end
        if (flush)
            for (int i = 0; i < N; i++) m_valid[i] = 0;
    endfunction

    task automatic tick();
        @(posedge clk);
        m_step();
        @(negedge clk);
        vectors++;
        if (lk_hit !== e_hit || lk_miss !== e_miss || lk_paddr !== e_paddr ||
            lk_prev_used !== e_pu || lk_prev_dirty !== e_pd) begin
            fails++;
            $display("FAIL %s: got hit=%b miss=%b pa=%h pu=%b pd=%b, expected hit=%b miss=%b pa=%h pu=%b pd=%b",
                     cur_req, lk_hit, lk_miss, lk_paddr, lk_prev_used, lk_prev_dirty,
                     e_hit, e_miss, e_paddr, e_pu, e_pd);
        end
    endtask

    task automatic op(input bit lv, input bit wr, input bit [31:0] va,
                      input bit fv, input bit [19:0] fvpn, input bit [19:0] fppn,
                      input bit fu, input bit fd, input bit fl);
        lk_valid = lv; lk_write = wr; lk_vaddr = va;
        fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn;
        fill_used = fu; fill_dirty = fd; flush = fl;
        tick();
    endtask

    task automatic look(input bit [19:0] vpn, input bit [11:0] off, input bit wr);
        op(1, wr, {vpn, off}, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic fill(input bit [19:0] vpn, input bit [19:0] ppn, input bit u, input bit d);
        op(0, 0, 0, 1, vpn, ppn, u, d, 0);
    endtask

    task automatic idle();
        op(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got no completion, expected end of run");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: empty after reset
        cur_req = "R10";
        idle();
        look(20'h00000, 12'h000, 0);
        look(20'h12345, 12'hABC, 0);

        // R2: misses and idle cycles
        cur_req = "R2";
        look(20'h00042, 12'h010, 1);
        idle();

        // R1: basic translations
        cur_req = "R1";
        fill(20'h00010, 20'hA0010, 1, 0);
        fill(20'h00011, 20'hB0011, 1, 0);
        look(20'h00010, 12'h123, 0);
        look(20'h00011, 12'hFFF, 0);
        look(20'h00010, 12'h000, 0);

        // R3 / R4: status bit history
        cur_req = "R3";
        fill(20'h00020, 20'hC0020, 0, 0);
        look(20'h00020, 12'h004, 0);
        look(20'h00020, 12'h008, 0);
        cur_req = "R4";
        look(20'h00020, 12'h00C, 1);
        look(20'h00020, 12'h010, 0);
        look(20'h00011, 12'h020, 0);

        // R9: lookup and refill of the same page together
        cur_req = "R9";
        op(1, 1, {20'h00030, 12'h555}, 1, 20'h00030, 20'hD0030, 0, 0, 0);
        look(20'h00030, 12'h556, 0);
        op(1, 0, {20'h00010, 12'h001}, 1, 20'h00031, 20'hD0031, 1, 1, 0);
        look(20'h00031, 12'h002, 0);

        // R7: rewrite of an existing page
        cur_req = "R7";
        fill(20'h00010, 20'hE0010, 0, 1);
        look(20'h00010, 12'h444, 0);
        look(20'h00011, 12'h444, 0);

        // R8: flush, with a refill in the same cycle discarded
        cur_req = "R8";
        op(0, 0, 0, 1, 20'h00040, 20'hF0040, 1, 0, 1);
        look(20'h00040, 12'h000, 0);
        look(20'h00010, 12'h000, 0);
        look(20'h00031, 12'h000, 0);

        // R5: partial fill keeps everything
        cur_req = "R5";
        for (int i = 0; i < 5; i++) fill(20'h00100 + i, 20'h10100 + i, 0, 0);
        for (int i = 0; i < 5; i++) look(20'h00100 + i, 12'h0F0, 0);

        // R6: full buffer evicts least recent
        cur_req = "R6";
        for (int i = 5; i < N; i++) fill(20'h00100 + i, 20'h10100 + i, 0, 0);
        look(20'h00105, 12'h001, 0);
        fill(20'h00200, 20'h20200, 0, 0);
        look(20'h00100, 12'h001, 0);
        look(20'h00105, 12'h001, 0);
        fill(20'h00201, 20'h20201, 0, 0);
        for (int i = 0; i < N; i++) look(20'h00100 + i, 12'h002, 0);
        look(20'h00200, 12'h003, 0);

        // Mixed random traffic over a small page pool
        cur_req = "R9";
        for (int n = 0; n < 3000; n++) begin
            op(($urandom % 4) != 0, $urandom % 2,
               {20'($urandom % 24), 12'($urandom)},
               ($urandom % 3) == 0, 20'($urandom % 24), 20'($urandom),
               $urandom % 2, $urandom % 2, ($urandom % 64) == 0);
        end
        idle();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule